// File: doc/BRIEF.md
# Buffered Buzzer Tone Generator

This block produces a square-wave buzzer tone. A bus-side write strobe stores a setting word into a holding buffer. The word has an 8-bit period field and a 6-bit high-time field, each encoded as a count minus one. On the next enabled edge of the sound clock, the held setting moves into the active sound register. The tone then runs from the active register until a stop command arrives. Software can queue the next setting while the current tone plays. The new setting takes over cleanly at the next sound-clock tick.

The sound clock is modelled as a single-cycle enable, `snd_tick`, inside the system clock domain. Three status flags support a handshake with software:
- `buf_empty` shows that the holding buffer may be refilled.
- `busy` shows that a tone is active.
- `out_done` marks that a stop has completed.

The empty and done flags are cleared by writing 1 to them. Two complementary outputs drive the buzzer. A polarity control swaps their levels.

Top module: `tone_buzzer`

## Requirements
- R1: A pulse on `wr_data` stores `wr_freq`/`wr_len` in the holding buffer and drives `buf_empty` to 0 on the next clock. This holds even when a flag clear or a transfer occurs in the same cycle.
- R2: While the buffer holds unloaded data and no stop is requested, the first cycle with `snd_tick`=1 copies it into the active register. On the following clock, `buf_empty`=1 and `busy`=1.
- R3: With a legal setting, the tone period is `freq`+1 sound-clock ticks, giving exactly one rising edge per period.
- R4: With a legal setting, the tone is at its active level for `len`+1 ticks in every period.
- R5: A pulse on `stop_cmd` has these effects on the next clock: `busy`=0, `out_done`=1, and `buf_empty`=1. Any held but unloaded setting is discarded unless a write arrives in that same cycle. A stop also overrides a same-cycle transfer.
- R6: Writing 1 to `flag_clr[0]` clears `buf_empty`, and writing 1 to `flag_clr[1]` clears `out_done`. A set event for a flag in the same cycle wins over its clear.
- R7: `tone_out_n` is always the inverse of `tone_out`. With `inv_sel`=0 the active level of `tone_out` is 1; with `inv_sel`=1 it is 0.
- R8: While `busy`=0, `tone_out` equals `inv_sel` on the next clock, which is the inactive level.
- R9: A prohibited setting is either `freq`=0 or `freq` <= `len`. When one is active, the outputs stay at the inactive level.
- R10: After reset, the outputs read as follows: `buf_empty`=1, `busy`=0, `out_done`=0, `tone_out`=0 and `tone_out_n`=1.
- R11: Each load into the active register restarts the waveform from the start of its high phase. The first active output appears two clocks after the load edge's write, and it lasts `len`+1 ticks.
- R12: The waveform and the buffer transfer advance only on cycles with `snd_tick`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| snd_tick | input | 1 | Sound-clock enable, one cycle per tick |
| wr_data | input | 1 | Write strobe for the holding buffer |
| wr_freq | input | 8 | Period field, ticks minus one |
| wr_len | input | 6 | High-time field, ticks minus one |
| stop_cmd | input | 1 | Stop request pulse |
| flag_clr | input | 2 | Write-1-to-clear: bit 0 buffer-empty, bit 1 done |
| inv_sel | input | 1 | Output polarity select |
| buf_empty | output | 1 | Holding buffer may be refilled |
| busy | output | 1 | Tone active |
| out_done | output | 1 | Stop completed |
| tone_out | output | 1 | Tone output |
| tone_out_n | output | 1 | Complementary tone output |

## Verification
The main function is driven with a table of settings:
- Short and full-range periods at both polarities. Counting active samples and rising edges over exactly two periods separates a period error from a high-time error, independent of phase.
- Prohibited settings, where the length equals or exceeds the period, or the period is zero. These show whether the legality guard holds the output inactive.
- A sparse tick pattern. This separates counting per sound tick from counting per system clock.

A mid-tone reload shows whether the counter restarts at the high phase. Same-cycle pairs of stop, write, transfer and flag clear exercise the stated priorities.

// File: rtl/tone_pkg.sv
package tone_pkg;
  parameter int FREQ_W = 8;
  parameter int LEN_W  = 6;
  parameter int CLR_W  = 2;

  localparam int CLR_EMPTY = 0;
  localparam int CLR_DONE  = 1;

  typedef struct packed {
    logic [FREQ_W-1:0] freq;
    logic [LEN_W-1:0]  len;
  } tone_cfg_t;

  function automatic logic cfg_legal(tone_cfg_t c);
    return (c.freq != '0) && (c.freq > FREQ_W'(c.len));
  endfunction
endpackage

// File: rtl/tone_buffer.sv
module tone_buffer
  import tone_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  tone_cfg_t wr_cfg,
  input  logic      take,
  input  logic      flush,
  output tone_cfg_t hold_cfg,
  output logic      pending
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cfg <= '0;
      pending  <= 1'b0;
    end else begin
      if (wr_en) begin
        hold_cfg <= wr_cfg;
        pending  <= 1'b1;
      end else if (take || flush) begin
        pending  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tone_flags.sv
module tone_flags
  import tone_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             load,
  input  logic             stop,
  input  logic [CLR_W-1:0] clr,
  output logic             empty,
  output logic             busy,
  output logic             done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      empty <= 1'b1;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      if (wr_en)                empty <= 1'b0;
      else if (load || stop)    empty <= 1'b1;
      else if (clr[CLR_EMPTY])  empty <= 1'b0;

      if (stop)                 busy <= 1'b0;
      else if (load)            busy <= 1'b1;

      if (stop)                 done <= 1'b1;
      else if (clr[CLR_DONE])   done <= 1'b0;
    end
  end
endmodule

// File: rtl/tone_wave.sv
module tone_wave
  import tone_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      load,
  input  tone_cfg_t load_cfg,
  input  logic      run,
  output logic      level
);
  tone_cfg_t         act_cfg;
  logic [FREQ_W-1:0] cnt;
  logic              legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_cfg <= '0;
      cnt     <= '0;
    end else if (load) begin
      act_cfg <= load_cfg;
      cnt     <= '0;
    end else if (run && tick) begin
      cnt <= (cnt >= act_cfg.freq) ? '0 : cnt + 1'b1;
    end
  end

  always_comb begin
    legal = cfg_legal(act_cfg);
    level = run && legal && (cnt <= FREQ_W'(act_cfg.len));
  end
endmodule

// File: rtl/tone_buzzer.sv
module tone_buzzer
  import tone_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              snd_tick,
  input  logic              wr_data,
  input  logic [FREQ_W-1:0] wr_freq,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic              stop_cmd,
  input  logic [CLR_W-1:0]  flag_clr,
  input  logic              inv_sel,
  output logic              buf_empty,
  output logic              busy,
  output logic              out_done,
  output logic              tone_out,
  output logic              tone_out_n
);
  tone_cfg_t wcfg, hold_cfg;
  logic      pending, take, raw;

  always_comb begin
    wcfg.freq = wr_freq;
    wcfg.len  = wr_len;
    take      = snd_tick && pending && !stop_cmd;
  end

  tone_buffer u_buf (
    .clk(clk), .rst(rst), .wr_en(wr_data), .wr_cfg(wcfg),
    .take(take), .flush(stop_cmd), .hold_cfg(hold_cfg), .pending(pending)
  );

  tone_flags u_flags (
    .clk(clk), .rst(rst), .wr_en(wr_data), .load(take), .stop(stop_cmd),
    .clr(flag_clr), .empty(buf_empty), .busy(busy), .done(out_done)
  );

  tone_wave u_wave (
    .clk(clk), .rst(rst), .tick(snd_tick), .load(take),
    .load_cfg(hold_cfg), .run(busy), .level(raw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tone_out   <= 1'b0;
      tone_out_n <= 1'b1;
    end else begin
      tone_out   <= raw ^ inv_sel;
      tone_out_n <= ~(raw ^ inv_sel);
    end
  end
endmodule

// File: rtl/tone_buzzer_chk.sv
module tone_buzzer_chk
  import tone_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             snd_tick,
  input logic             wr_data,
  input logic             stop_cmd,
  input logic [CLR_W-1:0] flag_clr,
  input logic             inv_sel,
  input logic             buf_empty,
  input logic             busy,
  input logic             out_done,
  input logic             tone_out,
  input logic             tone_out_n
);
  p_write_empty_r1: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> !buf_empty);

  p_load_flags_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_data && !stop_cmd) ##1 (snd_tick && !wr_data && !stop_cmd) |=> (buf_empty && busy));

  p_stop_r5: assert property (@(posedge clk) disable iff (rst)
    stop_cmd |=> (!busy && out_done));

  p_done_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_clr[CLR_DONE] && !stop_cmd) |=> !out_done);

  p_idle_level_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |=> ((tone_out == $past(inv_sel)) && (tone_out_n != $past(inv_sel))));
endmodule

bind tone_buzzer tone_buzzer_chk u_chk (
  .clk(clk), .rst(rst), .snd_tick(snd_tick), .wr_data(wr_data),
  .stop_cmd(stop_cmd), .flag_clr(flag_clr), .inv_sel(inv_sel),
  .buf_empty(buf_empty), .busy(busy), .out_done(out_done),
  .tone_out(tone_out), .tone_out_n(tone_out_n)
);

// File: tb/tone_buzzer_tb_top.sv
`timescale 1ns/1ps
module tone_buzzer_tb_top;
  import tone_pkg::*;

  logic clk = 1'b0, rst = 1'b1, snd_tick = 1'b0, wr_data = 1'b0;
  logic stop_cmd = 1'b0, inv_sel = 1'b0;
  logic [CLR_W-1:0]  flag_clr = '0;
  logic [FREQ_W-1:0] wr_freq = '0;
  logic [LEN_W-1:0]  wr_len = '0;
  logic buf_empty, busy, out_done, tone_out, tone_out_n;

  tone_buzzer dut_i (
    .clk(clk), .rst(rst), .snd_tick(snd_tick), .wr_data(wr_data),
    .wr_freq(wr_freq), .wr_len(wr_len), .stop_cmd(stop_cmd),
    .flag_clr(flag_clr), .inv_sel(inv_sel), .buf_empty(buf_empty),
    .busy(busy), .out_done(out_done), .tone_out(tone_out), .tone_out_n(tone_out_n)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0;

  // {freq, len, inv}
  localparam int NV = 9;
  localparam logic [14:0] VEC [NV] = '{
    {8'd9,   6'd4,  1'b0},
    {8'd9,   6'd4,  1'b1},
    {8'd3,   6'd0,  1'b0},
    {8'd255, 6'd63, 1'b0},
    {8'd1,   6'd0,  1'b1},
    {8'd5,   6'd5,  1'b0},
    {8'd0,   6'd0,  1'b0},
    {8'd2,   6'd3,  1'b1},
    {8'd9,   6'd4,  1'b0}
  };

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_write(int f, int l);
    wr_freq = FREQ_W'(f); wr_len = LEN_W'(l); wr_data = 1'b1;
    step();
    wr_data = 1'b0;
  endtask

  initial begin
    #1_500_000;
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int f, l, inv, p, highs, rises, mism, expv;
    bit legal, s, prev;
    #1;
    repeat (3) step();
    rst = 1'b0;
    step();
    // R10 reset state
    chk(buf_empty == 1'b1, "R10 empty", buf_empty, 1);
    chk(busy == 1'b0, "R10 busy", busy, 0);
    chk(out_done == 1'b0, "R10 done", out_done, 0);
    chk(tone_out == 1'b0 && tone_out_n == 1'b1, "R10 outputs", tone_out, 0);
    // R8 / R7 idle level follows polarity
    inv_sel = 1'b1; step(); step();
    chk(tone_out == 1'b1 && tone_out_n == 1'b0, "R8 idle inverted", tone_out, 1);
    inv_sel = 1'b0; step(); step();
    // R1 write clears empty; R12 no transfer without tick
    snd_tick = 1'b0;
    do_write(9, 4);
    chk(buf_empty == 1'b0, "R1 empty after write", buf_empty, 0);
    repeat (3) step();
    chk(busy == 1'b0, "R12 no load without tick", busy, 0);
    // R2 transfer on tick
    snd_tick = 1'b1; step();
    chk(buf_empty == 1'b1, "R2 empty set", buf_empty, 1);
    chk(busy == 1'b1, "R2 busy set", busy, 1);

    // table walk: R3 R4 R7 R9
    for (int v = 0; v < NV; v++) begin
      f = int'(VEC[v][14:7]); l = int'(VEC[v][6:1]); inv = int'(VEC[v][0]);
      legal = (f != 0) && (f > l);
      p = f + 1;
      inv_sel = VEC[v][0]; snd_tick = 1'b1;
      do_write(f, l);
      repeat (4) step();
      prev = tone_out ^ inv_sel;
      highs = 0; rises = 0; mism = 0;
      for (int i = 0; i < 2 * p; i++) begin
        step();
        s = tone_out ^ inv_sel;
        if (s) highs++;
        if (s && !prev) rises++;
        if (tone_out_n == tone_out) mism++;
        prev = s;
      end
      expv = legal ? 2 * (l + 1) : 0;
      chk(highs == expv, legal ? "R4 high ticks" : "R9 prohibited high ticks", highs, expv);
      expv = legal ? 2 : 0;
      chk(rises == expv, legal ? "R3 period edges" : "R9 prohibited edges", rises, expv);
      chk(mism == 0, "R7 complement", mism, 0);
    end

    // R11 reload restarts at high phase (running 9/4, not inverted)
    inv_sel = 1'b0;
    do_write(7, 2);
    step();
    for (int i = 0; i < 3; i++) begin
      step();
      chk(tone_out == 1'b1, "R11 high after reload", tone_out, 1);
    end
    step();
    chk(tone_out == 1'b0, "R11 low after len+1", tone_out, 0);

    // R12 slow tick: freq 4 len 1, tick every third clock
    snd_tick = 1'b0;
    do_write(4, 1);
    highs = 0;
    for (int k = 0; k < 39; k++) begin
      snd_tick = (k % 3 == 0);
      step();
      if (k >= 9 && tone_out) highs++;
    end
    chk(highs == 12, "R12 high clocks at slow tick", highs, 12);

    // R5 stop
    snd_tick = 1'b1; stop_cmd = 1'b1; step(); stop_cmd = 1'b0;
    chk(busy == 1'b0, "R5 busy cleared", busy, 0);
    chk(out_done == 1'b1, "R5 done set", out_done, 1);
    highs = 0;
    for (int i = 0; i < 6; i++) begin step(); if (tone_out) highs++; end
    chk(highs == 0, "R8 inactive after stop", highs, 0);

    // R6 done clear and collision
    flag_clr = 2'b10; step(); flag_clr = '0;
    chk(out_done == 1'b0, "R6 done cleared", out_done, 0);
    stop_cmd = 1'b1; flag_clr = 2'b10; step(); stop_cmd = 1'b0; flag_clr = '0;
    chk(out_done == 1'b1, "R6 set beats clear", out_done, 1);

    // R6 empty clear and collision with transfer
    flag_clr = 2'b01; step(); flag_clr = '0;
    chk(buf_empty == 1'b0, "R6 empty cleared", buf_empty, 0);
    snd_tick = 1'b0;
    do_write(9, 4);
    snd_tick = 1'b1; flag_clr = 2'b01; step(); flag_clr = '0;
    chk(buf_empty == 1'b1, "R6 load beats clear", buf_empty, 1);
    chk(busy == 1'b1, "R2 busy on load", busy, 1);

    // R5 stop discards held data
    snd_tick = 1'b0;
    do_write(9, 4);
    stop_cmd = 1'b1; step(); stop_cmd = 1'b0;
    snd_tick = 1'b1; repeat (3) step();
    chk(busy == 1'b0, "R5 held data discarded", busy, 0);
    chk(buf_empty == 1'b1, "R5 empty after stop", buf_empty, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule